// File: doc/BRIEF.md
# Double-Buffered TDM Frame Address Sequencer

This block produces the word addresses for a DMA engine that moves TDM frames between memory and a serial port. It has one transmit direction, which reads memory, and one receive direction, which writes memory. Each direction owns a ring in memory split into two halves. Software programs three byte addresses per direction: the first word of the ring, the first word of the second half, and the last 32-bit word of the ring. Each half holds a number of 32-byte frames, so the second-half address is start + frames*32 and the last-word address is start + 2*frames*32 - 4. The receive ring normally sits directly after the transmit ring.

On each frame tick, while transfers are enabled, the block issues one burst of eight transmit reads followed by eight receive writes. It uses a request/acknowledge memory port, and the address advances by 4 on each acknowledged word. When a pointer passes its last word it returns to its start address without any software action. A status bit records each half that completes, so an interrupt handler can tell which half is now free to refill or drain. Two more status bits record bus aborts. The status bits are cleared by writing ones to them, and a mask selects which of them drive a level interrupt.

Top module: `tdm_pingpong_addr`

## Requirements
- R1: After reset, mem_req and irq are low, int_status is zero, and the control field holds its reset value 4'hF, which keeps the engine idle.
- R2: The register index (cfg_addr) map is: 0 control, 1 operate, 2 mask, 3 status, 4/5/6 transmit start/second-half/last-word, 7/8/9 receive start/second-half/last-word. A frame tick with operate bit 0 set and control bits 3:1 clear starts a burst. The burst is 8 reads (mem_we low) from the transmit pointer, then 8 writes (mem_we high) from the receive pointer. Each pointer rises by 4 per acknowledged word.
- R3: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_we hold their values.
- R4: Once the word at a direction's last-word address is acknowledged, that direction's next address is its start address.
- R5: Status bit 0 (transmit) or bit 3 (receive) is set when the word just before that direction's second-half address is acknowledged. This marks the first half as complete.
- R6: Status bit 1 (transmit) or bit 2 (receive) is set when the word at that direction's last-word address is acknowledged. This marks the second half as complete.
- R7: A pulse on master_abort sets status bit 4, and a pulse on target_abort sets status bit 5.
- R8: Writing to the status index clears the status bits written as ones and leaves the others unchanged. A bit that is set and cleared in the same cycle ends up set.
- R9: irq is high exactly when some status bit and the same mask bit are both set.
- R10: A frame tick is ignored while operate is clear, and also while a burst is in progress.
- R11: While any of control bits 3:1 is set, no request is issued, a burst in progress is dropped, and both pointers return to their start addresses. Writing 4'h1 to control lets the engine run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | AW | Register write data |
| frame_tick | input | 1 | One-cycle pulse per TDM frame |
| mem_ack | input | 1 | Memory accepts the current word |
| master_abort | input | 1 | Bus master abort pulse |
| target_abort | input | 1 | Bus target abort pulse |
| mem_req | output | 1 | Word transfer request |
| mem_we | output | 1 | High for receive writes, low for transmit reads |
| mem_addr | output | AW | Byte address of the current word |
| irq | output | 1 | Level interrupt |
| int_status | output | 6 | Interrupt status bits |

## Verification
The bench runs enough frames to cross both half boundaries and the wrap point, and it inserts random acknowledge stalls. A design that advanced on an unacknowledged cycle, or that wrapped one word early or late, would show a wrong address. A design that signalled the second half at the second-half address itself would show the wrong status bits. Directed cases cover the following: a tick during a burst and a tick with operate clear, which a faulty design would answer with an extra burst; a clear that lands in the same cycle as an abort, which a faulty design would lose; a mask that hides some sources; and a hold followed by a restart, which must resume at the start addresses.

// File: rtl/tdm_dma_pkg.sv
// Shared types for the TDM frame address sequencer.
// Assumes a 4-bit register index and six status sources.
package tdm_dma_pkg;
    localparam int STAT_W = 6;
    localparam int ST_TX_FIRST  = 0;
    localparam int ST_TX_SECOND = 1;
    localparam int ST_RX_SECOND = 2;
    localparam int ST_RX_FIRST  = 3;
    localparam int ST_MABORT    = 4;
    localparam int ST_TABORT    = 5;

    typedef enum logic [3:0] {
        RA_CTRL  = 4'd0,
        RA_OPER  = 4'd1,
        RA_MASK  = 4'd2,
        RA_STAT  = 4'd3,
        RA_RING0 = 4'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_TX   = 2'd1,
        SQ_RX   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/tdm_dma_regs.sv
// Register file: control, operate, mask, write-one-to-clear status and
// three ring addresses per direction. Assumes single-cycle write strobes;
// a status set wins over a clear of the same bit in the same cycle.
module tdm_dma_regs
    import tdm_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [3:0]             idx,
    input  logic [AW-1:0]          wdata,
    input  logic [STAT_W-1:0]      set_vec,
    output logic                   hold,
    output logic                   oper,
    output logic [STAT_W-1:0]      status,
    output logic                   irq,
    output logic [1:0][AW-1:0]     ring_start,
    output logic [1:0][AW-1:0]     ring_mid,
    output logic [1:0][AW-1:0]     ring_last
);
    logic [3:0]        ctrl_q;
    logic              oper_q;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] clr_vec;
    logic              unused_bits;

    assign unused_bits = ^{wdata[AW-1:STAT_W], ctrl_q[0]};

    // Control and operate registers; reset holds the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 4'hF;
            oper_q <= 1'b0;
            mask_q <= '0;
        end else if (wr) begin
            if (idx == RA_CTRL) ctrl_q <= wdata[3:0];
            if (idx == RA_OPER) oper_q <= wdata[0];
            if (idx == RA_MASK) mask_q <= wdata[STAT_W-1:0];
        end
    end

    assign clr_vec = (wr && idx == RA_STAT) ? wdata[STAT_W-1:0] : '0;

    // Status: clear written ones, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    genvar d;
    generate
        for (d = 0; d < 2; d++) begin : g_dir
            localparam logic [3:0] BASE = 4'(int'(RA_RING0) + 3 * d);
            logic [AW-1:0] start_q, mid_q, last_q;
            // Ring address registers for one direction
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_q <= '0;
                    mid_q   <= '0;
                    last_q  <= '0;
                end else if (wr) begin
                    if (idx == BASE)        start_q <= wdata;
                    if (idx == BASE + 4'd1) mid_q   <= wdata;
                    if (idx == BASE + 4'd2) last_q  <= wdata;
                end
            end
            assign ring_start[d] = start_q;
            assign ring_mid[d]   = mid_q;
            assign ring_last[d]  = last_q;
        end
    endgenerate

    assign hold   = |ctrl_q[3:1];
    assign oper   = oper_q;
    assign status = stat_q;
    assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/tdm_dma_ptr.sv
// Address pointer for one ring direction. It steps by one 32-bit word per
// accepted transfer, returns to start after the last word, and flags the
// completion of each half. Assumes word-aligned, consistent ring addresses.
module tdm_dma_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] mid_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] ptr,
    output logic          first_done,
    output logic          second_done
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] nxt;
    logic          at_last;

    assign nxt     = ptr_q + WORD_BYTES;
    assign at_last = (ptr_q == last_addr);

    // Pointer: follow start while held, else advance or wrap on a step
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (hold)  ptr_q <= start_addr;
        else if (step)  ptr_q <= at_last ? start_addr : nxt;
    end

    assign ptr         = ptr_q;
    assign first_done  = step && !hold && !at_last && (nxt == mid_addr);
    assign second_done = step && !hold && at_last;
endmodule

// File: rtl/tdm_dma_seq.sv
// Burst sequencer: on an accepted frame tick it issues WPF transmit words,
// then WPF receive words, each waiting for mem_ack. Ticks during a burst
// are dropped, and a hold abandons the burst.
module tdm_dma_seq
    import tdm_dma_pkg::*;
#(
    parameter int WPF = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       oper,
    input  logic       tick,
    input  logic       ack,
    output logic       req,
    output logic       we,
    output logic [1:0] step
);
    localparam int CW = (WPF > 1) ? $clog2(WPF) : 1;
    localparam logic [CW-1:0] LAST = CW'(WPF - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    // Burst state and word counter
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (tick && oper) begin
                    state_q <= SQ_TX;
                    cnt_q   <= '0;
                end
                SQ_TX: if (ack) begin
                    if (cnt_q == LAST) begin
                        state_q <= SQ_RX;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                SQ_RX: if (ack) begin
                    if (cnt_q == LAST) begin
                        state_q <= SQ_IDLE;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign req     = (state_q != SQ_IDLE);
    assign we      = (state_q == SQ_RX);
    assign step[0] = (state_q == SQ_TX) && ack;
    assign step[1] = (state_q == SQ_RX) && ack;
endmodule

// File: rtl/tdm_pingpong_addr.sv
// Top: double-buffered TDM frame address sequencer. Direction 0 is
// transmit (memory reads), direction 1 is receive (memory writes).
// Assumes frame_tick and abort inputs are single-cycle pulses.
module tdm_pingpong_addr
    import tdm_dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int WPF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              frame_tick,
    input  logic              mem_ack,
    input  logic              master_abort,
    input  logic              target_abort,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic              irq,
    output logic [STAT_W-1:0] int_status
);
    logic                hold_w, oper_w;
    logic [1:0]          step_w, first_w, second_w;
    logic [1:0][AW-1:0]  start_w, mid_w, last_w, ptr_w;
    logic [STAT_W-1:0]   set_w;

    assign set_w[ST_TX_FIRST]  = first_w[0];
    assign set_w[ST_TX_SECOND] = second_w[0];
    assign set_w[ST_RX_SECOND] = second_w[1];
    assign set_w[ST_RX_FIRST]  = first_w[1];
    assign set_w[ST_MABORT]    = master_abort;
    assign set_w[ST_TABORT]    = target_abort;

    tdm_dma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_addr),
        .wdata(cfg_wdata), .set_vec(set_w), .hold(hold_w), .oper(oper_w),
        .status(int_status), .irq(irq), .ring_start(start_w),
        .ring_mid(mid_w), .ring_last(last_w)
    );

    tdm_dma_seq #(.WPF(WPF)) u_seq (
        .clk(clk), .rst_n(rst_n), .hold(hold_w), .oper(oper_w),
        .tick(frame_tick), .ack(mem_ack), .req(mem_req), .we(mem_we),
        .step(step_w)
    );

    genvar d;
    generate
        for (d = 0; d < 2; d++) begin : g_ptr
            tdm_dma_ptr #(.AW(AW)) u_ptr (
                .clk(clk), .rst_n(rst_n), .hold(hold_w), .step(step_w[d]),
                .start_addr(start_w[d]), .mid_addr(mid_w[d]),
                .last_addr(last_w[d]), .ptr(ptr_w[d]),
                .first_done(first_w[d]), .second_done(second_w[d])
            );
        end
    endgenerate

    assign mem_addr = mem_we ? ptr_w[1] : ptr_w[0];
endmodule

// File: rtl/tdm_dma_chk.sv
// Checker bound to the sequencer top; observes ports and pointer state.
module tdm_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          master_abort,
    input logic          target_abort,
    input logic [5:0]    int_status,
    input logic [AW-1:0] tx_ptr,
    input logic [AW-1:0] tx_start,
    input logic [AW-1:0] tx_last
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_req && int_status == 6'd0)); // R1
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !hold) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
    AST_TX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && !hold && mem_addr == tx_last) |=> (tx_ptr == $past(tx_start))); // R4
    AST_TX_SECOND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && !hold && mem_addr == tx_last) |=> int_status[1]); // R6
    AST_MASTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        master_abort |=> int_status[4]); // R7
    AST_TARGET_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        target_abort |=> int_status[5]); // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !mem_req); // R11
endmodule

bind tdm_pingpong_addr tdm_dma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold(hold_w), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .master_abort(master_abort), .target_abort(target_abort),
    .int_status(int_status), .tx_ptr(ptr_w[0]), .tx_start(start_w[0]),
    .tx_last(last_w[0])
);

// File: tb/sim_tdm_pingpong_addr.sv
module sim_tdm_pingpong_addr;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int WPF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic frame_tick = 1'b0, mem_ack = 1'b0;
    logic master_abort = 1'b0, target_abort = 1'b0;
    logic mem_req, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [5:0] int_status;

    int checks = 0;
    int failures = 0;
    logic [31:0] rs[2], rm[2], rl[2], ep[2];
    logic [5:0] est;
    logic [5:0] emask;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_pingpong_addr #(.AW(AW), .WPF(WPF)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_tick(frame_tick), .mem_ack(mem_ack),
        .master_abort(master_abort), .target_abort(target_abort),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .irq(irq), .int_status(int_status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] v);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic expected_irq(input logic [5:0] st, input logic [5:0] m);
        return |(st & m);
    endfunction

    // Model of one acknowledged word for direction d
    task automatic model_step(input int d);
        if (ep[d] == rl[d]) begin
            est[d == 0 ? 1 : 2] = 1'b1;
            ep[d] = rs[d];
        end else begin
            ep[d] = ep[d] + 32'd4;
            if (ep[d] == rm[d]) est[d == 0 ? 0 : 3] = 1'b1;
        end
    endtask

    task automatic run_frame(input bit inject);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        for (int i = 0; i < 2 * WPF; i++) begin
            int d;
            int n;
            d = (i < WPF) ? 0 : 1;
            n = $urandom % 3;
            for (int k = 0; k <= n; k++) begin
                check(ep[d] == rs[d] ? "R4 wrap address" : "R2 address", mem_addr, ep[d]);
                check("R3 request held", {30'd0, mem_req, mem_we}, {30'd0, 1'b1, d[0]});
                if (k < n) @(negedge clk);
            end
            mem_ack = 1'b1;
            if (inject && i == 5) frame_tick = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            frame_tick = 1'b0;
            model_step(d);
        end
        check("R2 burst ends", {31'd0, mem_req}, 32'd0);
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check("R10 tick during burst ignored", {31'd0, mem_req}, 32'd0);
            end
        end
        check("R5/R6 status", {26'd0, int_status}, {26'd0, est});
        check("R9 irq", {31'd0, irq}, {31'd0, expected_irq(est, emask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rs[0] = 32'h1000; rm[0] = 32'h1040; rl[0] = 32'h107C;
        rs[1] = 32'h1080; rm[1] = 32'h10C0; rl[1] = 32'h10FC;
        est = '0; emask = 6'h3F;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", {31'd0, mem_req}, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 status after reset", {26'd0, int_status}, 32'd0);
        // Reset control value holds the engine even with operate set
        wr_reg(4'd1, 32'd1);
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
        check("R1 held by reset control", {31'd0, mem_req}, 32'd0);
        for (int d = 0; d < 2; d++) begin
            wr_reg(4'(4 + 3 * d), rs[d]);
            wr_reg(4'(5 + 3 * d), rm[d]);
            wr_reg(4'(6 + 3 * d), rl[d]);
        end
        wr_reg(4'd2, 32'h3F);
        wr_reg(4'd0, 32'h1);
        ep[0] = rs[0]; ep[1] = rs[1];
        for (int f = 0; f < 6; f++) run_frame(f == 2);

        // R8: clear first-half bits only
        wr_reg(4'd3, 32'h09);
        est = est & ~6'h09;
        check("R8 W1C", {26'd0, int_status}, {26'd0, est});

        // R9: mask selects sources
        emask = 6'h01; wr_reg(4'd2, {26'd0, emask});
        check("R9 masked irq", {31'd0, irq}, {31'd0, expected_irq(est, emask)});
        emask = 6'h02; wr_reg(4'd2, {26'd0, emask});
        check("R9 enabled irq", {31'd0, irq}, {31'd0, expected_irq(est, emask)});

        // R7: aborts
        master_abort = 1'b1; @(negedge clk); master_abort = 1'b0;
        est[4] = 1'b1;
        check("R7 master abort", {26'd0, int_status}, {26'd0, est});
        target_abort = 1'b1;
        wr_reg(4'd3, 32'h20);
        target_abort = 1'b0;
        est[5] = 1'b1;
        check("R8 set wins over clear", {26'd0, int_status}, {26'd0, est});
        wr_reg(4'd3, 32'h3F);
        est = '0;
        check("R8 clear all", {26'd0, int_status}, 32'd0);
        check("R9 irq low", {31'd0, irq}, 32'd0);

        // R10: operate clear
        wr_reg(4'd1, 32'd0);
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R10 operate off", {31'd0, mem_req}, 32'd0);
            @(negedge clk);
        end
        wr_reg(4'd1, 32'd1);
        run_frame(1'b0);

        // R11: hold, relocate rings, restart at start
        wr_reg(4'd0, 32'h0F);
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
        check("R11 hold no request", {31'd0, mem_req}, 32'd0);
        rs[0] = 32'h2000; rm[0] = 32'h2020; rl[0] = 32'h203C;
        rs[1] = 32'h2040; rm[1] = 32'h2060; rl[1] = 32'h207C;
        for (int d = 0; d < 2; d++) begin
            wr_reg(4'(4 + 3 * d), rs[d]);
            wr_reg(4'(5 + 3 * d), rm[d]);
            wr_reg(4'(6 + 3 * d), rl[d]);
        end
        wr_reg(4'd0, 32'h1);
        ep[0] = rs[0]; ep[1] = rs[1];
        emask = 6'h3F; wr_reg(4'd2, 32'h3F);
        for (int f = 0; f < 3; f++) run_frame(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule